// File: doc/BRIEF.md
# Hashing Chain Bring-up Sequencer

This block is a host-side controller that discovers how many hashing chips sit on a serial daisy chain. It has a start input. When started, it broadcasts a chain reset and then polls until the chain echoes that reset back. It then broadcasts a self-test start and polls again until that echo arrives. One further two-byte transfer then returns the number of chips. The block finishes with a one-cycle done pulse. Alongside the pulse it reports one of three results: a valid chip count, a timeout, or a transfer error.

The block does no serial shifting itself. It talks to a byte-wide transfer engine through a request/acknowledge handshake. The sequencer holds a request with a byte to send and marks the second byte of each two-byte transaction. The engine answers with an acknowledge, the byte it received and an error flag. A whole probe is limited to 3.75 seconds of clock time, derived from a clock-frequency parameter.

Top module: `chain_enum_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `byte_req_o`, `done_o`, `timeout_o`, `error_o` and `count_valid_o` are 0, and `chip_count_o` is 0.
- R2: A start accepted while idle opens a command frame: byte 0x04 (chain reset), then byte 0x00 (broadcast address). `byte_last_o` is 1 only on the second byte. Each byte stays on `byte_tx_o`, with `byte_req_o` high, until the cycle in which `byte_ack_i` is 1.
- R3: After every command frame, the block polls with two-byte transactions whose transmitted bytes are both 0x00. `byte_last_o` marks the second byte.
- R4: A poll counts as an echo only when the first received byte equals the pending command code exactly (all 8 bits) and the second equals 0x00. Any other pair starts another poll.
- R5: After the reset echo, the block sends the frame 0x01 (self-test start), 0x00, and then polls for an echo of 0x01.
- R6: After the self-test echo, one more two-byte transfer of 0x00 bytes follows. Its second received byte appears on `chip_count_o` with `count_valid_o` set. `done_o` is high for exactly the one cycle after the final acknowledge.
- R7: With T = CLK_HZ*15/4, a probe that is still running at the (T+1)-th clock edge after the start edge ends at that edge. At that point `done_o` and `timeout_o` are set, `count_valid_o` is 0, `chip_count_o` is 0 and the request drops, even if a byte is being acknowledged.
- R8: An acknowledge with `byte_err_i` set ends the probe at that edge, with `done_o` and `error_o` set, `count_valid_o` 0 and `chip_count_o` 0.
- R9: `start_i` has no effect while busy. A start accepted while idle clears `timeout_o`, `error_o`, `count_valid_o` and `chip_count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a probe (used only while idle) |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle pulse when a probe ends |
| timeout_o | output | 1 | Last probe ran out of time |
| error_o | output | 1 | Last probe hit a transfer error |
| count_valid_o | output | 1 | `chip_count_o` holds a discovered count |
| chip_count_o | output | 8 | Number of chips reported by the chain |
| byte_req_o | output | 1 | Byte transfer requested |
| byte_tx_o | output | 8 | Byte to transmit |
| byte_last_o | output | 1 | Current byte closes a two-byte transaction |
| byte_ack_i | input | 1 | Engine completes the requested byte |
| byte_rx_i | input | 8 | Byte received during the acknowledged transfer |
| byte_err_i | input | 1 | Engine reports a failed transfer (with ack) |

## Verification
A wrong phase or byte index inside the sequencer shows up at `byte_tx_o` or `byte_last_o` within one acknowledged byte. So the bench compares the transmitted stream byte by byte against a transcript it builds from the requirements. A poll matched on the wrong rule, such as a partial compare or the wrong pending command, shows up as an extra or missing poll transaction. That difference appears at the next byte after the second poll byte is acknowledged. A timer that is off by even one cycle moves the done pulse off the exact edge that the bench expects.

// File: rtl/chain_enum_pkg.sv
package chain_enum_pkg;

    localparam logic [7:0] CMD_CHAIN_RST = 8'h04;
    localparam logic [7:0] CMD_SELFTEST  = 8'h01;
    localparam logic [7:0] ADDR_ALL      = 8'h00;
    localparam logic [7:0] FILL_BYTE     = 8'h00;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CMD   = 2'd1,
        PH_POLL  = 2'd2,
        PH_COUNT = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic       idx;
        logic [7:0] cmd;
        logic [7:0] rx0;
        logic       done;
        logic       tmo;
        logic       err;
        logic       valid;
        logic [7:0] count;
    } seq_state_t;

endpackage

// File: rtl/enum_timer.sv
module enum_timer #(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic zero_o
);
    localparam longint unsigned LIMIT = (longint'(CLK_HZ) * 15) / 4;
    localparam int unsigned     CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(LIMIT);
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/enum_echo_match.sv
module enum_echo_match
    import chain_enum_pkg::*;
(
    input  logic [7:0] pending_i,
    input  logic [7:0] first_i,
    input  logic [7:0] second_i,
    output logic       hit_o
);
    assign hit_o = (first_i == pending_i) && (second_i == ADDR_ALL);
endmodule

// File: rtl/enum_tx_mux.sv
module enum_tx_mux
    import chain_enum_pkg::*;
(
    input  phase_e     phase_i,
    input  logic       idx_i,
    input  logic [7:0] cmd_i,
    output logic [7:0] tx_o
);
    always_comb begin
        unique case (phase_i)
            PH_CMD:  tx_o = idx_i ? ADDR_ALL : cmd_i;
            default: tx_o = FILL_BYTE;
        endcase
    end
endmodule

// File: rtl/chain_enum_seq.sv
module chain_enum_seq
    import chain_enum_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       timeout_o,
    output logic       error_o,
    output logic       count_valid_o,
    output logic [7:0] chip_count_o,
    output logic       byte_req_o,
    output logic [7:0] byte_tx_o,
    output logic       byte_last_o,
    input  logic       byte_ack_i,
    input  logic [7:0] byte_rx_i,
    input  logic       byte_err_i
);
    seq_state_t s_d, s_q;
    logic       tmr_load;
    logic       tmr_zero;
    logic       echo_hit;
    logic       fire;

    enum_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (busy_o),
        .zero_o (tmr_zero)
    );

    enum_echo_match u_match (
        .pending_i (s_q.cmd),
        .first_i   (s_q.rx0),
        .second_i  (byte_rx_i),
        .hit_o     (echo_hit)
    );

    enum_tx_mux u_txmux (
        .phase_i (s_q.phase),
        .idx_i   (s_q.idx),
        .cmd_i   (s_q.cmd),
        .tx_o    (byte_tx_o)
    );

    assign busy_o        = (s_q.phase != PH_IDLE);
    assign byte_req_o    = busy_o;
    assign byte_last_o   = busy_o && s_q.idx;
    assign done_o        = s_q.done;
    assign timeout_o     = s_q.tmo;
    assign error_o       = s_q.err;
    assign count_valid_o = s_q.valid;
    assign chip_count_o  = s_q.count;
    assign fire          = byte_req_o && byte_ack_i;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start_i) begin
                s_d.phase = PH_CMD;
                s_d.idx   = 1'b0;
                s_d.cmd   = CMD_CHAIN_RST;
                s_d.tmo   = 1'b0;
                s_d.err   = 1'b0;
                s_d.valid = 1'b0;
                s_d.count = 8'h00;
                tmr_load  = 1'b1;
            end
        end else if (fire && byte_err_i) begin
            s_d.phase = PH_IDLE;
            s_d.idx   = 1'b0;
            s_d.err   = 1'b1;
            s_d.done  = 1'b1;
        end else if (tmr_zero) begin
            s_d.phase = PH_IDLE;
            s_d.idx   = 1'b0;
            s_d.tmo   = 1'b1;
            s_d.done  = 1'b1;
        end else if (fire) begin
            unique case (s_q.phase)
                PH_CMD: begin
                    if (!s_q.idx) begin
                        s_d.idx = 1'b1;
                    end else begin
                        s_d.idx   = 1'b0;
                        s_d.phase = PH_POLL;
                    end
                end
                PH_POLL: begin
                    if (!s_q.idx) begin
                        s_d.rx0 = byte_rx_i;
                        s_d.idx = 1'b1;
                    end else begin
                        s_d.idx = 1'b0;
                        if (echo_hit) begin
                            if (s_q.cmd == CMD_CHAIN_RST) begin
                                s_d.phase = PH_CMD;
                                s_d.cmd   = CMD_SELFTEST;
                            end else begin
                                s_d.phase = PH_COUNT;
                            end
                        end
                    end
                end
                PH_COUNT: begin
                    if (!s_q.idx) begin
                        s_d.idx = 1'b1;
                    end else begin
                        s_d.idx   = 1'b0;
                        s_d.phase = PH_IDLE;
                        s_d.count = byte_rx_i;
                        s_d.valid = 1'b1;
                        s_d.done  = 1'b1;
                    end
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, idx: 1'b0, cmd: 8'h00, rx0: 8'h00,
                     done: 1'b0, tmo: 1'b0, err: 1'b0, valid: 1'b0,
                     count: 8'h00};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/chain_enum_seq_chk.sv
module chain_enum_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       timeout_o,
    input logic       error_o,
    input logic       count_valid_o,
    input logic [7:0] chip_count_o,
    input logic       byte_req_o,
    input logic [7:0] byte_tx_o,
    input logic       byte_last_o,
    input logic       byte_ack_i,
    input logic [7:0] byte_rx_i,
    input logic       byte_err_i
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!byte_req_o && !byte_last_o)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req_o && !byte_ack_i) |=> (byte_req_o || timeout_o)); // R2

    AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req_o && !byte_ack_i) |=> (!byte_req_o || $stable(byte_tx_o))); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({timeout_o, error_o, count_valid_o}) == 1)); // R7

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req_o && byte_ack_i && byte_err_i) |=> (done_o && error_o && !count_valid_o)); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!timeout_o && !error_o && !count_valid_o)); // R9
endmodule

bind chain_enum_seq chain_enum_seq_chk u_chk (.*);

// File: tb/chain_enum_seq_tb.sv
`timescale 1ns/1ps
module chain_enum_seq_tb;
    localparam int unsigned CLK_HZ = 4000;
    localparam int          T      = (CLK_HZ * 15) / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       busy_o, done_o, timeout_o, error_o, count_valid_o;
    logic [7:0] chip_count_o;
    logic       byte_req_o, byte_last_o;
    logic [7:0] byte_tx_o;
    logic       byte_ack_i = 1'b0;
    logic [7:0] byte_rx_i = 8'h00;
    logic       byte_err_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #5 clk = ~clk;

    chain_enum_seq #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
        .error_o(error_o), .count_valid_o(count_valid_o),
        .chip_count_o(chip_count_o), .byte_req_o(byte_req_o),
        .byte_tx_o(byte_tx_o), .byte_last_o(byte_last_o),
        .byte_ack_i(byte_ack_i), .byte_rx_i(byte_rx_i),
        .byte_err_i(byte_err_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_byte(input logic [7:0] exp, input bit last, input string req);
        chk(byte_req_o && busy_o && !done_o, req, "request/busy", {byte_req_o, busy_o, done_o}, 3'b110);
        chk(byte_tx_o == exp, req, "tx byte", byte_tx_o, exp);
        chk(byte_last_o == last, req, "last flag", byte_last_o, last);
    endtask

    task automatic chk_result(input bit tmo, input bit err, input bit vld,
                              input logic [7:0] cnt, input string req);
        chk(done_o && !busy_o && !byte_req_o, req, "done pulse", {done_o, busy_o, byte_req_o}, 3'b100);
        chk({timeout_o, error_o, count_valid_o} == {tmo, err, vld}, req, "result flags",
            {timeout_o, error_o, count_valid_o}, {tmo, err, vld});
        chk(chip_count_o == cnt, req, "chip count", chip_count_o, cnt);
        @(negedge clk);
        chk(!done_o && !busy_o, req, "done drops", {done_o, busy_o}, 2'b00);
        chk({timeout_o, error_o, count_valid_o} == {tmo, err, vld}, req, "flags held",
            {timeout_o, error_o, count_valid_o}, {tmo, err, vld});
    endtask

    task automatic push(input logic [7:0] t0, input logic [7:0] t1,
                        input logic [7:0] r0, input logic [7:0] r1);
        txq.push_back(t0); txq.push_back(t1);
        rxq.push_back(r0); rxq.push_back(r1);
    endtask

    // Transcript: R2 reset frame, R3/R4 polls, R5 self-test frame, R6 count transfer
    task automatic build(input int rbad, input int sbad, input logic [7:0] cnt);
        txq.delete(); rxq.delete();
        push(8'h04, 8'h00, 8'h5A, 8'hA5);
        for (int k = 0; k < rbad; k++) begin
            case (k % 4)
                0: push(8'h00, 8'h00, 8'h04, 8'h03);
                1: push(8'h00, 8'h00, 8'h14, 8'h00);
                2: push(8'h00, 8'h00, 8'h01, 8'h00);
                default: push(8'h00, 8'h00, 8'hFF, 8'hFF);
            endcase
        end
        push(8'h00, 8'h00, 8'h04, 8'h00);
        push(8'h01, 8'h00, 8'h33, 8'h44);
        for (int k = 0; k < sbad; k++) begin
            case (k % 3)
                0: push(8'h00, 8'h00, 8'h04, 8'h00);
                1: push(8'h00, 8'h00, 8'h01, 8'h01);
                default: push(8'h00, 8'h00, 8'h81, 8'h00);
            endcase
        end
        push(8'h00, 8'h00, 8'h01, 8'h00);
        push(8'h00, 8'h00, 8'h77, cnt);
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!timeout_o && !error_o && !count_valid_o && chip_count_o == 8'h00, "R9",
            "flags cleared on start", {timeout_o, error_o, count_valid_o}, 0);
    endtask

    task automatic run(input int seed, input int err_at, input logic [7:0] cnt);
        string req;
        do_start();
        for (int i = 0; i < txq.size(); i++) begin
            req = (i < 2) ? "R2" : (txq[i] == 8'h01 ? "R5" : (i >= txq.size() - 2 ? "R6" : "R4"));
            for (int g = 0; g < (i + seed) % 3; g++) begin
                chk_byte(txq[i], i[0], req);
                @(negedge clk);
            end
            chk_byte(txq[i], i[0], req);
            byte_ack_i = 1'b1;
            byte_rx_i  = rxq[i];
            byte_err_i = (i == err_at);
            start_i    = (i == 5);   // R9: start while busy has no effect
            @(negedge clk);
            byte_ack_i = 1'b0;
            byte_err_i = 1'b0;
            start_i    = 1'b0;
            if (i == err_at) break;
        end
        if (err_at >= 0) chk_result(1'b0, 1'b1, 1'b0, 8'h00, "R8");
        else             chk_result(1'b0, 1'b0, 1'b1, cnt, "R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !byte_req_o && !done_o && !timeout_o && !error_o && !count_valid_o,
            "R1", "idle outputs", {busy_o, byte_req_o, done_o, timeout_o, error_o, count_valid_o}, 0);
        chk(chip_count_o == 8'h00, "R1", "count at reset", chip_count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !byte_req_o, "R1", "idle after release", {busy_o, byte_req_o}, 0);

        build(0, 0, 8'd12);  run(0, -1, 8'd12);
        build(4, 3, 8'd0);   run(1, -1, 8'd0);
        build(6, 5, 8'hFE);  run(2, -1, 8'hFE);

        // R7: timeout with no acknowledge at all
        do_start();
        for (int n = 0; n <= T; n++) begin
            chk_byte(8'h04, 1'b0, "R7");
            @(negedge clk);
        end
        chk_result(1'b1, 1'b0, 1'b0, 8'h00, "R7");

        // R8: transfer error mid-poll (also clears the timeout flag, R9)
        build(3, 0, 8'd5);   run(1, 7, 8'd5);

        // R7: timeout while the chain keeps answering without an echo
        do_start();
        byte_ack_i = 1'b1;
        byte_rx_i  = 8'hAA;
        for (int n = 0; n <= T; n++) begin
            chk_byte((n == 0) ? 8'h04 : 8'h00, n[0], "R7");
            @(negedge clk);
        end
        byte_ack_i = 1'b0;
        chk_result(1'b1, 1'b0, 1'b0, 8'h00, "R7");

        // R9: start after a timeout clears the flags and a full run completes
        build(1, 1, 8'd33);  run(0, -1, 8'd33);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule